// File: doc/BRIEF.md
# Write-Cycle Status Read Multiplexer

This block forms the byte returned to a reader of a byte-wide non-volatile memory. While no internal programming cycle runs, a read returns the addressed array byte unchanged. While the write controller holds its busy flag, a read returns a status byte instead. Software polls this status byte to find out when the write has finished, without waiting out a fixed worst-case delay.

The status byte has three fields. Bit 7 carries the inverse of bit 7 of the last byte written. A reader sees its own value come back true once the cycle ends. Bit 6 flips on every read made during the cycle and reads 0 first. Bit 5 mirrors the page-load timer: 0 while byte loading may still go on, 1 once the timer has expired. Bits 4 to 0 read 0 during a cycle. The bit 7 inversion does not depend on the address read, so the block needs no address inputs.

A read is a one-cycle strobe. The selected byte is registered and shows on `rd_data` in the cycle after the strobe, and it is held until the next strobe. A small state machine tracks the bit 6 flip-flop:

- States:
  - `TG_IDLE`: no cycle.
  - `TG_ZERO`: the next busy read returns 0.
  - `TG_ONE`: the next busy read returns 1.
- Transitions:
  - IDLE→ZERO when busy rises with no read.
  - IDLE→ONE when busy rises together with a read.
  - ZERO→ONE and ONE→ZERO on each read while busy.
  - Any state→IDLE when busy is low.

Top module: `wsm_status_mux`

## Requirements
- R1: With `busy` low, a strobe at clock edge N makes `rd_data` equal the `arr_data` present at edge N, visible after edge N.
- R2: With `busy` high, bit 7 of the returned byte is the inverse of bit 7 of `last_data`. This holds whatever the array data is, and so for the last written address and for any other address.
- R3: With `busy` high, bit 6 of the returned byte is 0 on the first read of the cycle and alternates 1, 0, 1, … on each later read of the same cycle.
- R4: With `busy` high, bit 5 of the returned byte equals `tmr_expired` (0 = timer running, 1 = timed out).
- R5: With `busy` high, bits 4 to 0 of the returned byte are 0, and no array data bit reaches the output.
- R6: Without a strobe, `rd_data` holds its value, even when `arr_data`, `busy` or the status inputs change.
- R7: After `busy` falls, reads again return the true array byte, including its real bit 7. A later cycle restarts bit 6 at 0, whatever its state when the previous cycle ended.
- R8: After reset, `rd_data` is 0 and the first busy read returns bit 6 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_stb | input | 1 | One-cycle read strobe |
| busy | input | 1 | Internal programming cycle in progress |
| last_data | input | DW | Last byte written |
| tmr_expired | input | 1 | Page-load timer status, 1 = expired |
| arr_data | input | DW | Array data for the addressed byte |
| rd_data | output | DW | Registered read data |

## Verification
The idle path is swept over all 256 array values, so any stuck or swapped passthrough bit is caught. Busy reads run over every combination of last-written bit 7 and timer status, with array data set to both all-ones and all-zeros. This separates the synthesized fields from leaked array bits. Runs of reads of different lengths, ended by dropping `busy` on both an odd and an even read count, show whether bit 6 alternates and restarts at 0. Non-strobe cycles with changing inputs show that the output holds.

// File: rtl/wsm_pkg.sv
package wsm_pkg;
    typedef enum logic [1:0] {
        TG_IDLE = 2'd0,
        TG_ZERO = 2'd1,
        TG_ONE  = 2'd2
    } tog_state_t;

    localparam int POLL_POS   = 7;
    localparam int TOGGLE_POS = 6;
    localparam int TIMER_POS  = 5;
endpackage

// File: rtl/wsm_toggle_fsm.sv
module wsm_toggle_fsm
    import wsm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic rd_stb,
    output logic tog_val
);
    tog_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TG_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TG_IDLE: begin
                if (busy && rd_stb) state_d = TG_ONE;
                else if (busy)      state_d = TG_ZERO;
            end
            TG_ZERO: begin
                if (!busy)       state_d = TG_IDLE;
                else if (rd_stb) state_d = TG_ONE;
            end
            TG_ONE: begin
                if (!busy)       state_d = TG_IDLE;
                else if (rd_stb) state_d = TG_ZERO;
            end
            default: state_d = TG_IDLE;
        endcase
    end

    // Output logic: value the current read would return on the toggle field
    always_comb begin
        unique case (state_q)
            TG_ONE:  tog_val = busy;
            default: tog_val = 1'b0;
        endcase
    end
endmodule

// File: rtl/wsm_status_compose.sv
module wsm_status_compose
    import wsm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          busy,
    input  logic          last_msb,
    input  logic          tmr_expired,
    input  logic          tog_val,
    input  logic [DW-1:0] arr_data,
    output logic [DW-1:0] sel_data
);
    logic [DW-1:0] status_byte;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (i == POLL_POS) begin : g_poll
            assign status_byte[i] = ~last_msb;
        end else if (i == TOGGLE_POS) begin : g_tog
            assign status_byte[i] = tog_val;
        end else if (i == TIMER_POS) begin : g_tmr
            assign status_byte[i] = tmr_expired;
        end else begin : g_zero
            assign status_byte[i] = 1'b0;
        end
    end

    assign sel_data = busy ? status_byte : arr_data;
endmodule

// File: rtl/wsm_status_mux.sv
module wsm_status_mux
    import wsm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_stb,
    input  logic          busy,
    input  logic [DW-1:0] last_data,
    input  logic          tmr_expired,
    input  logic [DW-1:0] arr_data,
    output logic [DW-1:0] rd_data
);
    logic          tog_val;
    logic [DW-1:0] sel_data;

    wsm_toggle_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .rd_stb  (rd_stb),
        .tog_val (tog_val)
    );

    wsm_status_compose #(.DW(DW)) u_comp (
        .busy        (busy),
        .last_msb    (last_data[POLL_POS]),
        .tmr_expired (tmr_expired),
        .tog_val     (tog_val),
        .arr_data    (arr_data),
        .sel_data    (sel_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_stb) rd_data <= sel_data;
    end
endmodule

// File: rtl/wsm_status_chk.sv
module wsm_status_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_stb,
    input logic          busy,
    input logic [DW-1:0] last_data,
    input logic          tmr_expired,
    input logic [DW-1:0] arr_data,
    input logic [DW-1:0] rd_data
);
    // Independent model of the toggle value the next busy read must show
    logic exp_tog;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            exp_tog <= 1'b0;
        else if (!busy)        exp_tog <= 1'b0;
        else if (rd_stb)       exp_tog <= ~exp_tog;
    end

    a_r1_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !busy) |=> rd_data == $past(arr_data));

    a_r2_poll_inv: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy) |=> rd_data[7] == !$past(last_data[7]));

    a_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy) |=> rd_data[6] == $past(exp_tog));

    a_r4_timer: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy) |=> rd_data[5] == $past(tmr_expired));

    a_r5_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy) |=> rd_data[4:0] == 5'd0);

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));
endmodule

bind wsm_status_mux wsm_status_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_stb      (rd_stb),
    .busy        (busy),
    .last_data   (last_data),
    .tmr_expired (tmr_expired),
    .arr_data    (arr_data),
    .rd_data     (rd_data)
);

// File: tb/sim_wsm_status_mux.sv
module sim_wsm_status_mux;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_stb = 1'b0;
    logic       busy = 1'b0;
    logic [7:0] last_data = 8'h00;
    logic       tmr_expired = 1'b0;
    logic [7:0] arr_data = 8'h00;
    logic [7:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    wsm_status_mux #(.DW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .busy(busy),
        .last_data(last_data), .tmr_expired(tmr_expired),
        .arr_data(arr_data), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Strobe one read at the next edge; sample at the following falling edge.
    task automatic do_read(input logic [7:0] arr);
        arr_data = arr;
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    function automatic logic [7:0] stat(input logic ld7, input logic tg, input logic tm);
        return {~ld7, tg, tm, 5'b00000};
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic tg;
        repeat (3) @(negedge clk);
        chk("R8 reset output", rd_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: idle passthrough sweep, last_data set to disturb nothing
        for (int v = 0; v < 256; v++) begin
            last_data = 8'(~v);
            do_read(8'(v));
            chk("R1 idle passthrough", rd_data, 8'(v));
        end

        // R8: first busy read after reset returns toggle 0
        busy = 1'b1; last_data = 8'h00; tmr_expired = 1'b0;
        do_read(8'hFF);
        chk("R8 first busy read after reset", rd_data, stat(1'b0, 1'b0, 1'b0));
        busy = 1'b0;
        @(negedge clk);

        // R2..R5: all status input combos, array all-ones and all-zeros
        for (int c = 0; c < 8; c++) begin
            logic ld7, tm;
            logic [7:0] arr;
            ld7 = c[0]; tm = c[1]; arr = c[2] ? 8'hFF : 8'h00;
            last_data = {ld7, 7'h55};
            tmr_expired = tm;
            busy = 1'b1;
            @(negedge clk);
            tg = 1'b0;
            for (int k = 0; k < 5; k++) begin
                do_read(arr ^ 8'(k));
                chk("R2/R3/R4/R5 busy status", rd_data, stat(ld7, tg, tm));
                chk("R2 poll bit", {7'b0, rd_data[7]}, {7'b0, ~ld7});
                chk("R3 toggle bit", {7'b0, rd_data[6]}, {7'b0, tg});
                chk("R4 timer bit", {7'b0, rd_data[5]}, {7'b0, tm});
                chk("R5 low bits zero", {3'b0, rd_data[4:0]}, 8'h00);
                tg = ~tg;
            end
            busy = 1'b0;
            @(negedge clk);
        end

        // R6: hold without strobe
        do_read(8'h3C);
        for (int k = 0; k < 6; k++) begin
            arr_data = 8'(k * 37);
            busy = k[0];
            tmr_expired = k[1];
            last_data = 8'(k * 91);
            @(negedge clk);
            chk("R6 hold without strobe", rd_data, 8'h3C);
        end
        busy = 1'b0;
        @(negedge clk);

        // R7: cycles ending on odd and even read counts, then restart
        for (int n = 1; n <= 4; n++) begin
            busy = 1'b1; last_data = 8'h80; tmr_expired = 1'b1;
            tg = 1'b0;
            for (int k = 0; k < n; k++) begin
                do_read(8'hA5);
                chk("R7 busy run", rd_data, stat(1'b1, tg, 1'b1));
                tg = ~tg;
            end
            busy = 1'b0;
            @(negedge clk);
            do_read(8'h80);
            chk("R7 true data after cycle", rd_data, 8'h80);
        end
        // R7: busy raised together with the strobe, first read still 0
        last_data = 8'h00; tmr_expired = 1'b0;
        busy = 1'b1;
        do_read(8'hFF);
        chk("R7 read on busy rise", rd_data, stat(1'b0, 1'b0, 1'b0));
        do_read(8'hFF);
        chk("R7 second read", rd_data, stat(1'b0, 1'b1, 1'b0));
        busy = 1'b0;
        do_read(8'h7E);
        chk("R7 read on busy fall", rd_data, 8'h7E);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule